// File: doc/BRIEF.md
# Shift-State Seven-Bit Character Decoder

The block turns each received seven-bit constant-ratio code into an ASCII byte. Every legal code word has exactly four ones among its seven bits. Each code is read through one of two character sets. A letters/figures state bit, held inside the block, chooses the set. Two reserved codes switch this state. Three further reserved codes mark idle and repeat conditions. These five reserved codes are consumed silently and are never shown as characters.

A receiver front end presents each recovered code together with a one-cycle strobe. One clock later the block answers with its own one-cycle strobe. The answer carries the ASCII byte and two flags. The print flag marks a displayable character. The error flag marks a code that breaks the four-ones rule or has no entry in either set. When neither flag is set, a control code was consumed.

Top module: `tor_char_decoder`

## Requirements
- R1: After reset, out_valid is 0 and the shift state is letters, so code 0x47 then decodes to 'A' (0x41).
- R2: In letters state, a code with four ones decodes to its letters character with out_print=1 and out_error=0. Examples: 0x47→'A', 0x56→'E', 0x74→'T', 0x2E→'Q', 0x6A→space (0x20), 0x6C→LF (0x0A), 0x78→CR (0x0D).
- R3: In figures state, the same codes decode to the figures set with out_print=1. Examples: 0x2D→'0', 0x2E→'1', 0x74→'5', 0x56→'3', 0x4B→BEL (0x07).
- R4: Code 0x36 sets the shift state to figures. Its response has out_print=0, out_error=0 and out_char=0x00.
- R5: Code 0x5A sets the shift state to letters in either state. Its response has out_print=0, out_error=0 and out_char=0x00.
- R6: Idle codes 0x33 and 0x0F and repeat code 0x66 give out_print=0, out_error=0 and out_char=0x00. They leave the shift state unchanged.
- R7: A code whose count of ones is not four gives out_error=1, out_print=0 and out_char=0x00, whatever the table holds. It leaves the shift state unchanged.
- R8: Each in_valid pulse produces exactly one out_valid pulse on the next cycle. Codes may arrive on back-to-back cycles, and each code sees the shift state left by the code before it. There is no out_valid without a preceding in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; restarts in letters state |
| in_valid | input | 1 | One-cycle strobe qualifying in_code |
| in_code | input | 7 | Received constant-ratio code |
| out_valid | output | 1 | One-cycle strobe, one cycle after in_valid |
| out_char | output | 8 | ASCII byte, 0x00 when nothing is printed |
| out_print | output | 1 | Response is a displayable character |
| out_error | output | 1 | Code has the wrong weight or no table entry |

## Verification
The hardest situation to reach is a decode that depends on the shift state when it follows a code that must not disturb that state. Examples are an idle, repeat or wrong-weight code arriving while in figures, or a reset arriving while in figures. The shift state is not visible at the ports. It only shows up in the character produced by the next printable code. The stimulus therefore mixes directed runs with a random stream drawn mostly from legal four-ones codes. Shift codes are weighted up so that figures spans are long. Corrupted codes are sprinkled in, and gaps are inserted between strobes. A mid-run reset is taken while in figures.

// File: rtl/tor_pkg.sv
package tor_pkg;
   localparam int unsigned TOR_CODE_W = 7;
   localparam int unsigned TOR_CHAR_W = 8;

   typedef enum logic [2:0] {
      CLS_PRINT,
      CLS_TO_FIGS,
      CLS_TO_LTRS,
      CLS_QUIET,
      CLS_BAD
   } code_class_e;
endpackage

// File: rtl/tor_weight_check.sv
module tor_weight_check #(
   parameter int unsigned CODE_W = 7,
   parameter int unsigned ONES   = 4,
   parameter bit          STRICT = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic              weight_ok
);
   localparam int unsigned CNT_W = $clog2(CODE_W + 1);

   generate
      if (STRICT) begin : g_strict
         logic [CNT_W-1:0] partial [CODE_W+1];
         assign partial[0] = '0;
         for (genvar i = 0; i < CODE_W; i++) begin : g_sum
            assign partial[i+1] = partial[i] + CNT_W'(code[i]);
         end
         assign weight_ok = (partial[CODE_W] == CNT_W'(ONES));
      end else begin : g_loose
         assign weight_ok = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tor_code_rom.sv
module tor_code_rom #(
   parameter int unsigned CODE_W = 7,
   parameter int unsigned CHAR_W = 8
) (
   input  logic              figs,
   input  logic [CODE_W-1:0] code,
   output logic [CHAR_W-1:0] ch,
   output logic              hit
);
   logic [CHAR_W-1:0] ltr_c, fig_c;

   always_comb begin
      hit   = 1'b1;
      ltr_c = '0;
      fig_c = '0;
      case (code)
         7'h17: begin ltr_c = "J"; fig_c = 8'h60; end
         7'h1B: begin ltr_c = "F"; fig_c = "!";   end
         7'h1D: begin ltr_c = "C"; fig_c = ":";   end
         7'h1E: begin ltr_c = "K"; fig_c = "(";   end
         7'h27: begin ltr_c = "W"; fig_c = "2";   end
         7'h2B: begin ltr_c = "Y"; fig_c = "6";   end
         7'h2D: begin ltr_c = "P"; fig_c = "0";   end
         7'h2E: begin ltr_c = "Q"; fig_c = "1";   end
         7'h35: begin ltr_c = "G"; fig_c = "&";   end
         7'h39: begin ltr_c = "M"; fig_c = ".";   end
         7'h3A: begin ltr_c = "X"; fig_c = "/";   end
         7'h3C: begin ltr_c = "V"; fig_c = ";";   end
         7'h47: begin ltr_c = "A"; fig_c = "-";   end
         7'h4B: begin ltr_c = "S"; fig_c = 8'h07; end
         7'h4D: begin ltr_c = "I"; fig_c = "8";   end
         7'h4E: begin ltr_c = "U"; fig_c = "7";   end
         7'h53: begin ltr_c = "D"; fig_c = "$";   end
         7'h55: begin ltr_c = "R"; fig_c = "4";   end
         7'h56: begin ltr_c = "E"; fig_c = "3";   end
         7'h59: begin ltr_c = "N"; fig_c = ",";   end
         7'h5C: begin ltr_c = " "; fig_c = " ";   end
         7'h63: begin ltr_c = "Z"; fig_c = 8'h22; end
         7'h65: begin ltr_c = "L"; fig_c = ")";   end
         7'h69: begin ltr_c = "H"; fig_c = "#";   end
         7'h6A: begin ltr_c = " "; fig_c = " ";   end
         7'h6C: begin ltr_c = 8'h0A; fig_c = 8'h0A; end
         7'h71: begin ltr_c = "O"; fig_c = "9";   end
         7'h72: begin ltr_c = "B"; fig_c = "?";   end
         7'h74: begin ltr_c = "T"; fig_c = "5";   end
         7'h78: begin ltr_c = 8'h0D; fig_c = 8'h0D; end
         default: hit = 1'b0;
      endcase
      ch = figs ? fig_c : ltr_c;
   end
endmodule

// File: rtl/tor_shift_state.sv
module tor_shift_state (
   input  logic clk,
   input  logic rst_n,
   input  logic go_figs,
   input  logic go_ltrs,
   output logic figs
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       figs <= 1'b0;
      else if (go_figs) figs <= 1'b1;
      else if (go_ltrs) figs <= 1'b0;
   end
endmodule

// File: rtl/tor_char_decoder.sv
module tor_char_decoder #(
   parameter int unsigned CODE_W    = tor_pkg::TOR_CODE_W,
   parameter int unsigned CHAR_W    = tor_pkg::TOR_CHAR_W,
   parameter int unsigned ONES      = 4,
   parameter bit          STRICT    = 1'b1,
   parameter logic [6:0]  FIGS_CODE = 7'h36,
   parameter logic [6:0]  LTRS_CODE = 7'h5A,
   parameter logic [6:0]  IDLE_A    = 7'h33,
   parameter logic [6:0]  IDLE_B    = 7'h0F,
   parameter logic [6:0]  RPT_CODE  = 7'h66
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_char,
   output logic              out_print,
   output logic              out_error
);
   import tor_pkg::*;

   generate
      if (CODE_W != 7) begin : g_bad_code_w
         $error("tor_char_decoder: CODE_W must be 7");
      end
      if (CHAR_W != 8) begin : g_bad_char_w
         $error("tor_char_decoder: CHAR_W must be 8");
      end
      if (ONES == 0 || ONES >= CODE_W) begin : g_bad_ones
         $error("tor_char_decoder: ONES out of range");
      end
   endgenerate

   logic              figs_q, weight_ok, rom_hit;
   logic [CHAR_W-1:0] rom_ch;
   code_class_e       cls;

   tor_weight_check #(.CODE_W(CODE_W), .ONES(ONES), .STRICT(STRICT)) u_weight (
      .code      (in_code),
      .weight_ok (weight_ok)
   );

   tor_code_rom #(.CODE_W(CODE_W), .CHAR_W(CHAR_W)) u_rom (
      .figs (figs_q),
      .code (in_code),
      .ch   (rom_ch),
      .hit  (rom_hit)
   );

   always_comb begin
      if (!weight_ok)                                      cls = CLS_BAD;
      else if (in_code == FIGS_CODE)                       cls = CLS_TO_FIGS;
      else if (in_code == LTRS_CODE)                       cls = CLS_TO_LTRS;
      else if (in_code == IDLE_A || in_code == IDLE_B ||
               in_code == RPT_CODE)                        cls = CLS_QUIET;
      else if (rom_hit)                                    cls = CLS_PRINT;
      else                                                 cls = CLS_BAD;
   end

   tor_shift_state u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_figs (in_valid && cls == CLS_TO_FIGS),
      .go_ltrs (in_valid && cls == CLS_TO_LTRS),
      .figs    (figs_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_char  <= '0;
         out_print <= 1'b0;
         out_error <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_print <= (cls == CLS_PRINT);
            out_error <= (cls == CLS_BAD);
            out_char  <= (cls == CLS_PRINT) ? rom_ch : '0;
         end
      end
   end
endmodule

// File: rtl/tor_char_decoder_chk.sv
module tor_char_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic [6:0] in_code,
   input logic       out_valid,
   input logic [7:0] out_char,
   input logic       out_print,
   input logic       out_error
);
   assert_one_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_weight_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && $countones(in_code) != 4) |=> (out_error && !out_print && out_char == 8'h00));
   assert_figs_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_code == 7'h36) |=> (!out_print && !out_error && out_char == 8'h00));
   assert_ltrs_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_code == 7'h5A) |=> (!out_print && !out_error && out_char == 8'h00));
   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_code == 7'h33 || in_code == 7'h0F || in_code == 7'h66))
      |=> (!out_print && !out_error));
   assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_print && out_error));
endmodule

bind tor_char_decoder tor_char_decoder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_code   (in_code),
   .out_valid (out_valid),
   .out_char  (out_char),
   .out_print (out_print),
   .out_error (out_error)
);

// File: tb/tb_tor_char_decoder.sv
`timescale 1ns/1ps
module tb_tor_char_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [6:0] in_code = '0;
   logic       out_valid, out_print, out_error;
   logic [7:0] out_char;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic       m_figs = 1'b0;
   logic       e_valid = 1'b0;
   logic [7:0] e_char = '0;
   logic       e_print = 1'b0, e_error = 1'b0;
   string      e_tag = "R1";

   always #2.5 clk = ~clk;

   tor_char_decoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
      .out_valid(out_valid), .out_char(out_char),
      .out_print(out_print), .out_error(out_error)
   );

   function automatic logic [7:0] ref_char(input logic f, input logic [6:0] c);
      logic [7:0] l, g;
      l = 8'h00; g = 8'h00;
      case (c)
         7'h47: begin l = "A"; g = "-"; end
         7'h72: begin l = "B"; g = "?"; end
         7'h1D: begin l = "C"; g = ":"; end
         7'h53: begin l = "D"; g = "$"; end
         7'h56: begin l = "E"; g = "3"; end
         7'h1B: begin l = "F"; g = "!"; end
         7'h35: begin l = "G"; g = "&"; end
         7'h69: begin l = "H"; g = "#"; end
         7'h4D: begin l = "I"; g = "8"; end
         7'h17: begin l = "J"; g = 8'h60; end
         7'h1E: begin l = "K"; g = "("; end
         7'h65: begin l = "L"; g = ")"; end
         7'h39: begin l = "M"; g = "."; end
         7'h59: begin l = "N"; g = ","; end
         7'h71: begin l = "O"; g = "9"; end
         7'h2D: begin l = "P"; g = "0"; end
         7'h2E: begin l = "Q"; g = "1"; end
         7'h55: begin l = "R"; g = "4"; end
         7'h4B: begin l = "S"; g = 8'h07; end
         7'h74: begin l = "T"; g = "5"; end
         7'h4E: begin l = "U"; g = "7"; end
         7'h3C: begin l = "V"; g = ";"; end
         7'h27: begin l = "W"; g = "2"; end
         7'h3A: begin l = "X"; g = "/"; end
         7'h2B: begin l = "Y"; g = "6"; end
         7'h63: begin l = "Z"; g = 8'h22; end
         7'h5C, 7'h6A: begin l = 8'h20; g = 8'h20; end
         7'h6C: begin l = 8'h0A; g = 8'h0A; end
         7'h78: begin l = 8'h0D; g = 8'h0D; end
         default: begin l = 8'h00; g = 8'h00; end
      endcase
      return f ? g : l;
   endfunction

   task automatic check_prev();
      total++;
      if (out_valid !== e_valid) begin
         bad++;
         $display("FAIL %s out_valid actual=%0b expected=%0b", e_valid ? e_tag : "R8", out_valid, e_valid);
      end else if (e_valid && (out_char !== e_char || out_print !== e_print || out_error !== e_error)) begin
         bad++;
         $display("FAIL %s actual char=%02h print=%0b err=%0b expected char=%02h print=%0b err=%0b",
                  e_tag, out_char, out_print, out_error, e_char, e_print, e_error);
      end
   endtask

   task automatic cyc(input logic v, input logic [6:0] c);
      @(negedge clk);
      check_prev();
      in_valid = v;
      in_code  = c;
      e_valid  = v;
      if (v) begin
         e_char = 8'h00; e_print = 1'b0; e_error = 1'b0;
         if ($countones(c) != 4) begin
            e_error = 1'b1; e_tag = "R7";
         end else if (c == 7'h36) begin
            m_figs = 1'b1; e_tag = "R4";
         end else if (c == 7'h5A) begin
            m_figs = 1'b0; e_tag = "R5";
         end else if (c == 7'h33 || c == 7'h0F || c == 7'h66) begin
            e_tag = "R6";
         end else if (ref_char(m_figs, c) == 8'h00) begin
            e_error = 1'b1; e_tag = "R7";
         end else begin
            e_char = ref_char(m_figs, c); e_print = 1'b1;
            e_tag = m_figs ? "R3" : "R2";
         end
      end
   endtask

   function automatic logic [6:0] rand_code();
      logic [6:0] c;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) return 7'h36;
      if (sel == 1) return 7'h5A;
      if (sel == 2) return 7'($urandom);
      c = 7'($urandom);
      while ($countones(c) != 4) c = 7'($urandom);
      return c;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R8 watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_0C0D));
      repeat (3) @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset out_valid actual=%0b expected=0", out_valid);
      end
      rst_n = 1'b1;
      cyc(1, 7'h47); // R1: letters after reset gives 'A'
      cyc(1, 7'h56); cyc(1, 7'h74); cyc(0, 7'h00); cyc(1, 7'h78); // R2
      cyc(1, 7'h6C); cyc(1, 7'h6A); cyc(1, 7'h2E);
      cyc(1, 7'h36); cyc(1, 7'h2D); cyc(1, 7'h2E); cyc(1, 7'h4B); // R4 R3
      cyc(1, 7'h33); cyc(1, 7'h74); cyc(1, 7'h0F); cyc(1, 7'h66); cyc(1, 7'h56); // R6
      cyc(1, 7'h7F); cyc(1, 7'h00); cyc(1, 7'h01); cyc(1, 7'h2D); // R7 keeps figures
      cyc(1, 7'h5A); cyc(1, 7'h5A); cyc(1, 7'h2D); // R5
      cyc(1, 7'h36); cyc(1, 7'h36); cyc(1, 7'h5A); cyc(1, 7'h74); // R8 back-to-back
      cyc(1, 7'h36); cyc(0, 7'h00); cyc(0, 7'h00);
      @(negedge clk);
      check_prev();
      rst_n = 1'b0; in_valid = 1'b0; e_valid = 1'b0; m_figs = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1, 7'h47); // R1: reset returns to letters
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 3) == 0) cyc(0, 7'($urandom));
         else cyc(1, rand_code());
      end
      cyc(0, 7'h00);
      cyc(0, 7'h00);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule